// File: doc/BRIEF.md
# Selectable Serial Line Codec

This block sits between a serial bit source and the physical line and converts plain bit values into one of five line codes: NRZ, NRZI, FM0 (bi-phase space), FM1 (bi-phase mark) and Manchester. The transmit side is driven by a half-cell strobe at twice the bit rate. On the first strobe of a cell it takes one bit from the source and drives the first-half level. On the second strobe it drives the second-half level. When no bit is offered at a cell boundary, the line rests at logical one.

The receive side takes an oversampling strobe and a separate cell-start marker, so that the bit-cell timing comes from outside. It samples the line once in each half of a marked cell and decodes the bit with the same code that the transmitter uses. It reports an FM0 or FM1 cell that has no transition at its start as a code violation. The code select input is taken in only while the transmitter is idle. Both directions use the selected code.

Top module: `line_codec`

## Requirements
- R1: After reset, tx_line is 1, and rx_valid and rx_viol are 0.
- R2: A half_tick at a cell boundary with tx_valid low drives tx_line to 1 from the next cycle, ends any stream in progress, and keeps the line at 1 until a bit is offered.
- R3: Code values on code_sel are 0 NRZ, 1 NRZI, 2 FM0, 3 FM1 and 4 Manchester. Values 5 to 7 behave as NRZ. In NRZ both halves of a cell equal the bit.
- R4: In NRZI a zero inverts the level held at the end of the previous cell, and a one keeps it; both halves are equal. Coming out of idle, the previous level is 1.
- R5: In FM0 the first half is the inverse of the previous level. The second half equals the first for a one and is inverted for a zero.
- R6: In FM1 the first half is the inverse of the previous level. The second half is inverted for a one and equal to the first for a zero.
- R7: In Manchester the first half equals the bit and the second half is its inverse.
- R8: code_sel is taken in only while no stream is in progress. A change during a stream has no effect on the cells of that stream.
- R9: tx_line is registered. It takes each half-cell level on the clock edge that samples the corresponding half_tick.
- R10: The decoder takes a sample on the rx_tick at position OVS/4 of a cell (the rx_cell tick is position 0) and another at position 3*OVS/4. The reference level is the sample from the rx_tick just before the cell. One cycle after the second sample it pulses rx_valid for one cycle, with rx_bit decoded according to R3 to R7.
- R11: rx_viol pulses together with rx_valid only when the code is FM0 or FM1 and the first-half sample equals the reference level. It never pulses for NRZ, NRZI or Manchester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_sel | input | 3 | Line code select |
| half_tick | input | 1 | Transmit half-cell strobe |
| tx_valid | input | 1 | A bit is offered at the next cell start |
| tx_bit | input | 1 | Bit to encode |
| tx_line | output | 1 | Encoded line level |
| rx_tick | input | 1 | Receive oversampling strobe |
| rx_cell | input | 1 | Marks the rx_tick that starts a cell to decode |
| rx_line | input | 1 | Received line level |
| rx_valid | output | 1 | Decoded bit is valid (one-cycle pulse) |
| rx_bit | output | 1 | Decoded bit |
| rx_viol | output | 1 | Missing start-of-cell transition in FM0/FM1 |

## Verification
The bench encodes the same bit pattern in every code and checks both halves of every cell against a level model. It then replays the captured waveform into the decoder and compares the recovered bits. A mix-up between FM0 and FM1, or a wrong NRZI polarity, would invert every affected bit, and a decoder that used the wrong reference level would fail on the first cell after idle. The bench changes the code select in the middle of a stream: a transmitter that took in the new code at once would switch its waveform from that cell on. The bench also feeds flat cells in FM0, FM1 and NRZ to check that the violation flag appears only for the transition-based codes. It checks that the line goes back to one when no bit is offered.

// File: rtl/line_codec_pkg.sv
package line_codec_pkg;
  typedef enum logic [2:0] {
    LC_NRZ  = 3'd0,
    LC_NRZI = 3'd1,
    LC_FM0  = 3'd2,
    LC_FM1  = 3'd3,
    LC_MAN  = 3'd4
  } lcode_t;

  function automatic lcode_t map_code(input logic [2:0] sel);
    case (sel)
      3'd1:    return LC_NRZI;
      3'd2:    return LC_FM0;
      3'd3:    return LC_FM1;
      3'd4:    return LC_MAN;
      default: return LC_NRZ;
    endcase
  endfunction

  function automatic logic is_fm(input lcode_t c);
    return (c == LC_FM0) || (c == LC_FM1);
  endfunction
endpackage

// File: rtl/line_enc.sv
module line_enc
  import line_codec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] code_sel,
  input  logic       half_tick,
  input  logic       tx_valid,
  input  logic       tx_bit,
  output logic       tx_line,
  output lcode_t     code
);
  lcode_t code_q;
  logic   line_q, busy_q, phase_q, h2_q;
  logic   h1_c, h2_c;

  // Half-cell levels for a new cell, given the level left by the previous one
  always_comb begin
    h1_c = tx_bit;
    h2_c = tx_bit;
    case (code_q)
      LC_NRZI: begin
        h1_c = tx_bit ? line_q : ~line_q;
        h2_c = h1_c;
      end
      LC_FM0: begin
        h1_c = ~line_q;
        h2_c = tx_bit ? h1_c : ~h1_c;
      end
      LC_FM1: begin
        h1_c = ~line_q;
        h2_c = tx_bit ? ~h1_c : h1_c;
      end
      LC_MAN: begin
        h1_c = tx_bit;
        h2_c = ~tx_bit;
      end
      default: begin
        h1_c = tx_bit;
        h2_c = tx_bit;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= LC_NRZ;
      line_q  <= 1'b1;
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      h2_q    <= 1'b1;
    end else begin
      if (!busy_q) code_q <= map_code(code_sel);
      if (half_tick) begin
        if (phase_q) begin
          line_q  <= h2_q;
          phase_q <= 1'b0;
        end else if (tx_valid) begin
          line_q  <= h1_c;
          h2_q    <= h2_c;
          phase_q <= 1'b1;
          busy_q  <= 1'b1;
        end else begin
          line_q <= 1'b1;
          busy_q <= 1'b0;
        end
      end
    end
  end

  assign tx_line = line_q;
  assign code    = code_q;

  // R2: leaving a stream parks the line at one
  a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> line_q);

  // R8: the code is frozen while a stream runs
  a_r8_code_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(code_q));

  // R5/R6: bi-phase cells always start with a transition
  a_r5_fm_start_toggle: assert property (@(posedge clk) disable iff (rst)
    (half_tick && !phase_q && tx_valid && is_fm(code_q)) |=> (line_q != $past(line_q)));

  // R7: Manchester always inverts at mid-cell
  a_r7_man_mid: assert property (@(posedge clk) disable iff (rst)
    (half_tick && phase_q && code_q == LC_MAN) |=> (line_q != $past(line_q)));
endmodule

// File: rtl/line_dec.sv
module line_dec
  import line_codec_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic   clk,
  input  logic   rst,
  input  lcode_t code,
  input  logic   rx_tick,
  input  logic   rx_cell,
  input  logic   rx_line,
  output logic   rx_valid,
  output logic   rx_bit,
  output logic   rx_viol
);
  localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] P1 = CW'(OVS / 4);
  localparam logic [CW-1:0] P2 = CW'(OVS / 2 + OVS / 4);

  logic [CW-1:0] cnt_q, pos_c;
  logic          act_q, last_q, ref_q, h1_q;
  logic          valid_q, bit_q, viol_q;
  logic          h1_c, bit_c, viol_c;

  assign pos_c = rx_cell ? '0 : cnt_q + 1'b1;
  assign h1_c  = (pos_c == P1) ? rx_line : h1_q;

  always_comb begin
    viol_c = 1'b0;
    case (code)
      LC_NRZI: bit_c = (h1_c == ref_q);
      LC_FM0: begin
        bit_c  = (h1_c == rx_line);
        viol_c = (h1_c == ref_q);
      end
      LC_FM1: begin
        bit_c  = (h1_c != rx_line);
        viol_c = (h1_c == ref_q);
      end
      default: bit_c = h1_c;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      act_q   <= 1'b0;
      last_q  <= 1'b1;
      ref_q   <= 1'b1;
      h1_q    <= 1'b1;
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      viol_q  <= 1'b0;
      if (rx_tick) begin
        last_q <= rx_line;
        cnt_q  <= pos_c;
        if (rx_cell) begin
          act_q <= 1'b1;
          ref_q <= last_q;
        end
        if ((act_q || rx_cell) && pos_c == P1) h1_q <= rx_line;
        if (act_q && !rx_cell && pos_c == P2) begin
          valid_q <= 1'b1;
          bit_q   <= bit_c;
          viol_q  <= viol_c;
          act_q   <= 1'b0;
        end
      end
    end
  end

  assign rx_valid = valid_q;
  assign rx_bit   = bit_q;
  assign rx_viol  = viol_q;

  // R10: a decoded bit is a single-cycle pulse
  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R11: violations only come with a bit and only for bi-phase codes
  a_r11_viol_fm_only: assert property (@(posedge clk) disable iff (rst)
    rx_viol |-> (rx_valid && $past(is_fm(code))));
endmodule

// File: rtl/line_codec.sv
module line_codec
  import line_codec_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] code_sel,
  input  logic       half_tick,
  input  logic       tx_valid,
  input  logic       tx_bit,
  output logic       tx_line,
  input  logic       rx_tick,
  input  logic       rx_cell,
  input  logic       rx_line,
  output logic       rx_valid,
  output logic       rx_bit,
  output logic       rx_viol
);
  lcode_t code;

  line_enc u_enc (
    .clk(clk), .rst(rst), .code_sel(code_sel), .half_tick(half_tick),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_line(tx_line), .code(code)
  );

  line_dec #(.OVS(OVS)) u_dec (
    .clk(clk), .rst(rst), .code(code), .rx_tick(rx_tick), .rx_cell(rx_cell),
    .rx_line(rx_line), .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_viol(rx_viol)
  );

  // R1: quiet outputs right after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (tx_line && !rx_valid && !rx_viol));
endmodule

// File: tb/line_codec_tb.sv
module line_codec_tb;
  localparam int OVS = 16;
  localparam int P1  = OVS / 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] code_sel = 3'd0;
  logic half_tick = 0, tx_valid = 0, tx_bit = 0, tx_line;
  logic rx_tick = 0, rx_cell = 0, rx_line = 1'b1;
  logic rx_valid, rx_bit, rx_viol;

  int checks = 0, errors = 0;
  logic hv1 [0:63];
  logic hv2 [0:63];
  logic got_b [0:63];
  logic got_v [0:63];
  int got_n = 0;

  always #10 clk = ~clk;

  line_codec #(.OVS(OVS)) u_dut (
    .clk(clk), .rst(rst), .code_sel(code_sel), .half_tick(half_tick),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_line(tx_line),
    .rx_tick(rx_tick), .rx_cell(rx_cell), .rx_line(rx_line),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_viol(rx_viol)
  );

  always @(negedge clk) begin
    if (rx_valid && got_n < 64) begin
      got_b[got_n] = rx_bit;
      got_v[got_n] = rx_viol;
      got_n = got_n + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected half-cell levels from the code rules
  task automatic model(input int c, input logic prev, input logic b,
                       output logic h1, output logic h2);
    case (c)
      1: begin h1 = b ? prev : ~prev; h2 = h1; end
      2: begin h1 = ~prev; h2 = b ? h1 : ~h1; end
      3: begin h1 = ~prev; h2 = b ? ~h1 : h1; end
      4: begin h1 = b; h2 = ~b; end
      default: begin h1 = b; h2 = b; end
    endcase
  endtask

  task automatic tick_tx(input logic v, input logic b);
    @(negedge clk);
    half_tick = 1'b1; tx_valid = v; tx_bit = b;
    @(negedge clk);
    half_tick = 1'b0; tx_valid = 1'b0;
  endtask

  // Encode n bits LSB first; optionally change code_sel mid stream
  task automatic enc_stream(input int c, input logic [7:0] d, input int n,
                            input int sw_at, input int alt, input string req);
    logic prev, h1, h2;
    code_sel = 3'(c);
    repeat (3) @(negedge clk);
    prev = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (i == sw_at) code_sel = 3'(alt);
      model(c, prev, d[i], h1, h2);
      tick_tx(1'b1, d[i]);
      chk(tx_line === h1, {req, " first half"}, int'(tx_line), int'(h1));
      @(negedge clk);
      tick_tx(1'b0, 1'b0);
      chk(tx_line === h2, {req, " second half"}, int'(tx_line), int'(h2));
      hv1[i] = h1; hv2[i] = h2; prev = h2;
    end
    tick_tx(1'b0, 1'b0);
    chk(tx_line === 1'b1, "R2 idle after stream", int'(tx_line), 1);
    repeat (2) @(negedge clk);
    chk(tx_line === 1'b1, "R2 idle held", int'(tx_line), 1);
    code_sel = 3'(c);
  endtask

  task automatic feed_idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      rx_line = 1'b1; rx_tick = 1'b1; rx_cell = 1'b0;
    end
    @(negedge clk);
    rx_tick = 1'b0;
  endtask

  task automatic feed_cell(input logic h1, input logic h2);
    for (int i = 0; i < OVS; i++) begin
      @(negedge clk);
      rx_line = (i < OVS / 2) ? h1 : h2;
      rx_tick = 1'b1;
      rx_cell = (i == 0);
    end
  endtask

  task automatic dec_replay(input int c, input logic [7:0] d, input int n, input string req);
    code_sel = 3'(c);
    feed_idle(2 * OVS);
    got_n = 0;
    for (int i = 0; i < n; i++) feed_cell(hv1[i], hv2[i]);
    @(negedge clk);
    rx_tick = 1'b0; rx_cell = 1'b0;
    repeat (3) @(negedge clk);
    chk(got_n == n, {req, " R10 bit count"}, got_n, n);
    for (int i = 0; i < n && i < got_n; i++) begin
      chk(got_b[i] === d[i], {req, " R10 decoded bit"}, int'(got_b[i]), int'(d[i]));
      chk(got_v[i] === 1'b0, {req, " R11 no violation"}, int'(got_v[i]), 0);
    end
  endtask

  task automatic t_reset;
    chk(tx_line === 1'b1, "R1 tx_line", int'(tx_line), 1);
    chk(rx_valid === 1'b0, "R1 rx_valid", int'(rx_valid), 0);
    chk(rx_viol === 1'b0, "R1 rx_viol", int'(rx_viol), 0);
  endtask

  task automatic t_codes;
    enc_stream(0, 8'hB4, 8, -1, 0, "R3 NRZ");   dec_replay(0, 8'hB4, 8, "R3 NRZ");
    enc_stream(1, 8'h3A, 8, -1, 0, "R4 NRZI");  dec_replay(1, 8'h3A, 8, "R4 NRZI");
    enc_stream(2, 8'hC5, 8, -1, 0, "R5 FM0");   dec_replay(2, 8'hC5, 8, "R5 FM0");
    enc_stream(3, 8'h96, 8, -1, 0, "R6 FM1");   dec_replay(3, 8'h96, 8, "R6 FM1");
    enc_stream(4, 8'h71, 8, -1, 0, "R7 Manchester"); dec_replay(4, 8'h71, 8, "R7 Manchester");
    enc_stream(6, 8'h5C, 8, -1, 0, "R3 code 6 as NRZ"); dec_replay(6, 8'h5C, 8, "R3 code 6");
  endtask

  task automatic t_timing;
    code_sel = 3'd4;
    repeat (3) @(negedge clk);
    @(negedge clk);
    half_tick = 1'b1; tx_valid = 1'b1; tx_bit = 1'b0;
    chk(tx_line === 1'b1, "R9 line before tick edge", int'(tx_line), 1);
    @(negedge clk);
    half_tick = 1'b0; tx_valid = 1'b0;
    chk(tx_line === 1'b0, "R9 line after tick edge", int'(tx_line), 0);
    tick_tx(1'b0, 1'b0);
    chk(tx_line === 1'b1, "R9 mid-cell level", int'(tx_line), 1);
    tick_tx(1'b0, 1'b0);
    chk(tx_line === 1'b1, "R2 end", int'(tx_line), 1);
  endtask

  task automatic t_code_hold;
    // stream starts in FM1; code_sel moves to Manchester at cell 3
    enc_stream(3, 8'h0F, 8, 3, 4, "R8 code change ignored");
    dec_replay(3, 8'h0F, 8, "R8 replay");
  endtask

  task automatic t_viol;
    // FM0: flat cell after idle (no start edge), then a legal one-cell
    code_sel = 3'd2;
    feed_idle(2 * OVS);
    got_n = 0;
    feed_cell(1'b1, 1'b1);
    feed_cell(1'b0, 1'b0);
    @(negedge clk); rx_tick = 1'b0; rx_cell = 1'b0;
    repeat (3) @(negedge clk);
    chk(got_n == 2, "R11 FM0 bit count", got_n, 2);
    chk(got_v[0] === 1'b1, "R11 FM0 violation flagged", int'(got_v[0]), 1);
    chk(got_v[1] === 1'b0, "R11 FM0 legal cell", int'(got_v[1]), 0);
    // FM1 flat cell after idle
    code_sel = 3'd3;
    feed_idle(2 * OVS);
    got_n = 0;
    feed_cell(1'b1, 1'b1);
    @(negedge clk); rx_tick = 1'b0; rx_cell = 1'b0;
    repeat (3) @(negedge clk);
    chk(got_v[0] === 1'b1, "R11 FM1 violation flagged", int'(got_v[0]), 1);
    // NRZ: same flat cell is not a violation
    code_sel = 3'd0;
    feed_idle(2 * OVS);
    got_n = 0;
    feed_cell(1'b1, 1'b1);
    @(negedge clk); rx_tick = 1'b0; rx_cell = 1'b0;
    repeat (3) @(negedge clk);
    chk(got_n == 1, "R11 NRZ bit count", got_n, 1);
    chk(got_v[0] === 1'b0, "R11 NRZ no violation", int'(got_v[0]), 0);
    chk(got_b[0] === 1'b1, "R10 NRZ bit", int'(got_b[0]), 1);
  endtask

  task automatic t_sample_point;
    // Level differs only at position P1 of the first half: decoder must use it
    code_sel = 3'd0;
    feed_idle(2 * OVS);
    got_n = 0;
    for (int i = 0; i < OVS; i++) begin
      @(negedge clk);
      rx_line = (i == P1) ? 1'b0 : 1'b1;
      rx_tick = 1'b1;
      rx_cell = (i == 0);
    end
    @(negedge clk); rx_tick = 1'b0; rx_cell = 1'b0;
    repeat (3) @(negedge clk);
    chk(got_n == 1 && got_b[0] === 1'b0, "R10 sample position", int'(got_b[0]), 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_timing();
    t_codes();
    t_code_hold();
    t_viol();
    t_sample_point();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule